// File: doc/BRIEF.md
# Fixed-Direction GPIO with Edge Interrupts

This block is an eight-line general-purpose I/O port reached through a small byte-wide register interface. The register interface has a 3-bit byte address, a write strobe with write data, and a read strobe with registered read data. The line directions are fixed and cannot be changed. Lines 0 to 3 are driven outputs. Lines 4 to 7 are inputs that arrive asynchronously and are synchronized inside the block.

Each input can be programmed to record a rising edge, a falling edge, or both. Every input has its own 2-bit edge-select field, and all four fields are packed into one configuration byte. A detected edge sets a sticky bit in an event status byte. Software clears status bits by writing ones to them. A single registered interrupt line stays high while any status bit is set.

Top module: `fixed_gpio_edge`

## Requirements
- R1: After a synchronous reset, the following are all zero: the edge configuration byte, the event status byte, `pin_out` and `irq`.
- R2: A read of offset 0 returns 0x0F, marking lines 0-3 as outputs and lines 4-7 as inputs. Writes to offset 0 have no effect.
- R3: A write to offset 1 drives `wdata[3:0]` onto `pin_out[3:0]` from the next cycle on. A read of offset 1 returns the synchronized input levels of lines 4-7 in bits [7:4] and the current output levels in bits [3:0].
- R4: The byte at offset 3 reads back as written. For input line 4+n, bit 2n enables falling-edge capture and bit 2n+1 enables rising-edge capture. Setting both bits captures either edge.
- R5: An input whose 2-bit field is 00 never sets its status bit.
- R6: Bit n of the status byte at offset 4 records an enabled edge on input line 4+n. A single transition of a line sets the bit exactly once. The bit becomes visible on the third rising clock edge after the pin changes.
- R7: Writing offset 4 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If an enabled edge and a clearing write hit the same status bit in the same cycle, the bit remains set.
- R9: `irq` is a registered OR of the status bits, lagging them by one cycle. It stays high until every status bit has been cleared.
- R10: Read data appears one cycle after the read strobe. Reads of offsets 2, 5, 6 and 7 return zero. In any cycle that follows no read, `rdata` is zero.
- R11: An input level change is visible in a read of offset 1 whose strobe comes two or more cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Asynchronous input lines 4-7 (bit n = line 4+n) |
| pin_out | output | 4 | Output lines 0-3 |
| irq | output | 1 | Interrupt request, high while any event is pending |

## Verification
The hardest case to reach from the ports is the collision in which a clearing write and a new edge land on the same status bit in the same clock cycle. The edge reaches the status register only after the synchronizer and the delay flop. The stimulus therefore changes the pin on a falling clock edge, counts exactly two rising edges, and then raises the write strobe so that it is sampled on the third rising edge, together with the event. Before this, the bit is set by an earlier edge, so a design in which the clear wins would show a zero in the read-back.

// File: rtl/fixed_gpio_pkg.sv
package fixed_gpio_pkg;

    localparam int N_OUT       = 4;
    localparam int N_IN        = 4;
    localparam int DATA_W      = N_OUT + N_IN;
    localparam int ADDR_W      = 3;
    localparam int SYNC_STAGES = 2;
    localparam int CFG_W       = 2 * N_IN;

    localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ECFG = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_EVST = 3'd4;

    // Fixed direction read-back: ones mark output lines
    localparam logic [DATA_W-1:0] DIR_VALUE = DATA_W'((1 << N_OUT) - 1);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_DATA,
        SEL_ECFG,
        SEL_EVST
    } reg_sel_t;

    typedef struct packed {
        logic rise_en;
        logic fall_en;
    } edge_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        case (a)
            OFS_DIR:  s = SEL_DIR;
            OFS_DATA: s = SEL_DATA;
            OFS_ECFG: s = SEL_ECFG;
            OFS_EVST: s = SEL_EVST;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic edge_hit(input edge_sel_t sel, input logic cur, input logic prev);
        return (sel.rise_en & cur & ~prev) | (sel.fall_en & ~cur & prev);
    endfunction

endpackage

// File: rtl/fixed_gpio_in_sync.sv
module fixed_gpio_in_sync
    import fixed_gpio_pkg::*;
#(
    parameter int W      = N_IN,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw_i;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign lvl_o  = chain[STAGES-1];
    assign prev_o = chain[STAGES];
endmodule

// File: rtl/fixed_gpio_edge_det.sv
module fixed_gpio_edge_det
    import fixed_gpio_pkg::*;
#(
    parameter int W = N_IN
) (
    input  logic [W-1:0]   cur_i,
    input  logic [W-1:0]   prev_i,
    input  logic [2*W-1:0] cfg_i,
    output logic [W-1:0]   evt_o
);
    for (genvar n = 0; n < W; n++) begin : g_line
        edge_sel_t sel;
        assign sel      = edge_sel_t'(cfg_i[2*n +: 2]);
        assign evt_o[n] = edge_hit(sel, cur_i[n], prev_i[n]);
    end
endmodule

// File: rtl/fixed_gpio_regs.sv
module fixed_gpio_regs
    import fixed_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [N_IN-1:0]   in_lvl_i,
    input  logic [N_IN-1:0]   evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_OUT-1:0]  out_o,
    output logic [CFG_W-1:0]  ecfg_o,
    output logic [N_IN-1:0]   evst_o
);
    reg_sel_t          sel;
    logic [N_OUT-1:0]  out_q;
    logic [CFG_W-1:0]  ecfg_q;
    logic [N_IN-1:0]   evst_q;
    logic [N_IN-1:0]   clr_mask;
    logic [N_IN-1:0]   evst_d;
    logic [DATA_W-1:0] rd_mux;

    assign sel = decode_addr(addr_i);

    assign clr_mask = (we_i && sel == SEL_EVST) ? wdata_i[N_IN-1:0] : '0;
    // New events take priority over a simultaneous clear
    assign evst_d   = (evst_q & ~clr_mask) | evt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            ecfg_q <= '0;
            evst_q <= '0;
        end else begin
            if (we_i && sel == SEL_DATA) out_q  <= wdata_i[N_OUT-1:0];
            if (we_i && sel == SEL_ECFG) ecfg_q <= wdata_i[CFG_W-1:0];
            evst_q <= evst_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:  rd_mux = DIR_VALUE;
            SEL_DATA: rd_mux = {in_lvl_i, out_q};
            SEL_ECFG: rd_mux = DATA_W'(ecfg_q);
            SEL_EVST: rd_mux = DATA_W'(evst_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= '0;
        else if (re_i) rdata_o <= rd_mux;
        else           rdata_o <= '0;
    end

    assign out_o  = out_q;
    assign ecfg_o = ecfg_q;
    assign evst_o = evst_q;
endmodule

// File: rtl/fixed_gpio_edge.sv
module fixed_gpio_edge
    import fixed_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_OUT-1:0]  pin_out,
    output logic              irq
);
    logic [N_IN-1:0]  in_lvl;
    logic [N_IN-1:0]  in_prev;
    logic [N_IN-1:0]  evt;
    logic [CFG_W-1:0] ecfg_q;
    logic [N_IN-1:0]  evst_q;

    fixed_gpio_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pin_in),
        .lvl_o  (in_lvl),
        .prev_o (in_prev)
    );

    fixed_gpio_edge_det #(.W(N_IN)) u_edge (
        .cur_i  (in_lvl),
        .prev_i (in_prev),
        .cfg_i  (ecfg_q),
        .evt_o  (evt)
    );

    fixed_gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .re_i     (bus_re),
        .in_lvl_i (in_lvl),
        .evt_i    (evt),
        .rdata_o  (bus_rdata),
        .out_o    (pin_out),
        .ecfg_o   (ecfg_q),
        .evst_o   (evst_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |evst_q;
    end
endmodule

// File: rtl/fixed_gpio_edge_chk.sv
module fixed_gpio_edge_chk
    import fixed_gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_OUT-1:0]  pin_out,
    input logic              irq,
    input logic [CFG_W-1:0]  ecfg_q,
    input logic [N_IN-1:0]   evst_q
);
    // R2
    dir_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == OFS_DIR) |=> bus_rdata == DIR_VALUE);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (bus_addr == 3'd2 || bus_addr > OFS_EVST)) |=> bus_rdata == '0);

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == '0);

    // R3
    out_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DATA) |=> pin_out == $past(bus_wdata[N_OUT-1:0]));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|evst_q));

    for (genvar n = 0; n < N_IN; n++) begin : g_bit
        // R5
        masked_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(evst_q[n]) |-> $past(ecfg_q[2*n +: 2]) != 2'b00);
        // R7
        clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(evst_q[n]) |-> $past(bus_we && bus_addr == OFS_EVST && bus_wdata[n]));
    end
endmodule

bind fixed_gpio_edge fixed_gpio_edge_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .ecfg_q    (ecfg_q),
    .evst_q    (evst_q)
);

// File: tb/fixed_gpio_edge_tb_top.sv
`timescale 1ns/1ps
module fixed_gpio_edge_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fixed_gpio_edge dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    // {cfg[7:0], pins_before[3:0], pins_after[3:0], expected_status[3:0]}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {8'h02, 4'b0000, 4'b0001, 4'b0001},
        {8'h02, 4'b0001, 4'b0000, 4'b0000},
        {8'h01, 4'b0001, 4'b0000, 4'b0001},
        {8'hFF, 4'b0000, 4'b1111, 4'b1111},
        {8'hFF, 4'b1111, 4'b0000, 4'b1111},
        {8'h00, 4'b0000, 4'b1111, 4'b0000},
        {8'h84, 4'b0010, 4'b1000, 4'b1010},
        {8'h30, 4'b0100, 4'b0000, 4'b0100}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_out", {4'h0, pin_out}, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
        rd(3'd3, v); check("R1 cfg", v, 8'h00);
        rd(3'd4, v); check("R1 status", v, 8'h00);

        // R2 direction fixed
        rd(3'd0, v); check("R2 dir", v, 8'h0F);
        wr(3'd0, 8'hA5);
        rd(3'd0, v); check("R2 dir after write", v, 8'h0F);

        // R10 unmapped offsets and idle data
        rd(3'd2, v); check("R10 off2", v, 8'h00);
        rd(3'd5, v); check("R10 off5", v, 8'h00);
        rd(3'd7, v); check("R10 off7", v, 8'h00);
        idle(1);
        check("R10 idle rdata", bus_rdata, 8'h00);

        // R3 output drive and data read-back
        wr(3'd1, 8'hF9);
        check("R3 pin_out", {4'h0, pin_out}, 8'h09);
        rd(3'd1, v); check("R3 data read", v, 8'h09);

        // R4 configuration read-back
        wr(3'd3, 8'h6C);
        rd(3'd3, v); check("R4 cfg readback", v, 8'h6C);

        // Vector table: R4 R5 R6 R9 R11
        for (int i = 0; i < NV; i++) begin
            logic [7:0] cfg;
            logic [3:0] pb, pa, ex;
            {cfg, pb, pa, ex} = VEC[i];
            wr(3'd3, 8'h00);
            pin_in = pb;
            idle(6);
            wr(3'd3, cfg);
            wr(3'd4, 8'h0F);
            idle(2);
            pin_in = pa;
            idle(6);
            rd(3'd4, v); check("R6 status (R4/R5 vector)", v, {4'h0, ex});
            check("R9 irq level", {7'h0, irq}, {7'h0, |ex});
            rd(3'd1, v); check("R11 input level", v[7:4], {4'h0, pa} << 0 >> 0 & 8'h0F);
            wr(3'd4, 8'h0F);
        end

        // R6 single transition yields a single event
        wr(3'd3, 8'h02);
        pin_in = 4'b0000;
        idle(6);
        wr(3'd4, 8'h0F);
        pin_in = 4'b0001;
        idle(6);
        wr(3'd4, 8'h01);
        idle(6);
        rd(3'd4, v); check("R6 no repeat event", v, 8'h00);

        // R6 latency: status not set before third edge
        wr(3'd3, 8'h01);
        @(negedge clk);
        pin_in = 4'b0000;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        check("R6 latency early", bus_rdata, 8'h00);
        rd(3'd4, v); check("R6 latency set", v, 8'h01);

        // R7 partial clear, R9 irq holds until all clear
        wr(3'd3, 8'h0A);
        pin_in = 4'b0011;
        idle(6);
        rd(3'd4, v); check("R7 two set", v, 8'h03);
        wr(3'd4, 8'hFE);
        rd(3'd4, v); check("R7 partial clear", v, 8'h01);
        check("R9 irq still high", {7'h0, irq}, 8'h01);
        wr(3'd4, 8'h01);
        check("R9 irq registered lag", {7'h0, irq}, 8'h01);
        idle(1);
        check("R9 irq low", {7'h0, irq}, 8'h00);

        // R8 event wins over simultaneous clear
        wr(3'd3, 8'h03);
        pin_in = 4'b0000;
        idle(6);
        rd(3'd4, v); check("R8 preset", v, 8'h01);
        @(negedge clk);
        pin_in = 4'b0001;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h01; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        rd(3'd4, v); check("R8 event wins", v, 8'h01);

        // R1 reset again clears state
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R1 pin_out after reset", {4'h0, pin_out}, 8'h00);
        rd(3'd4, v); check("R1 status after reset", v, 8'h00);

        finish_run();
    end
endmodule